// File: doc/BRIEF.md
# Radio Channel and Init Sequencer

This block sits on the controller side of a low-rate wireless transceiver that is reached over a serial register bus. It turns two one-cycle requests into ordered register writes, issued one at a time on a valid/acknowledge command port. The serial shifter that carries these writes to the transceiver is outside this block. Each command is either a short write (6-bit address) or a long write (10-bit address) with one data byte.

A start request brings the transceiver up with sixteen fixed writes. The list opens with a soft reset, follows with the radio tuning values, pulses the RF state machine reset, and closes by putting the receiver in normal mode. A channel request checks the channel number. It then writes the encoded channel, pulses the RF reset, and waits a settling time of 192 µs before it reports completion. The wait length in clock cycles comes from a clock-frequency parameter. Requests that arrive while a sequence is running are dropped, and `busy_o` shows when that is the case.

Top module: `rfseq_ctrl`

## Requirements
- R1: After reset, `busy_o`, `cmd_valid_o`, `done_o` and `err_o` are all low.
- R2: On `start_i` while idle, exactly 16 writes are issued in this order, as {long, address, data}: short 0x2A=0x07, short 0x18=0x98, short 0x2E=0x95, long 0x200=0x03, long 0x201=0x01, long 0x202=0x80, long 0x206=0x90, long 0x207=0x80, long 0x208=0x10, long 0x220=0x21, short 0x3A=0x80, short 0x3F=0x60, short 0x3E=0x40, short 0x36=0x04, short 0x36=0x00, short 0x00=0x00.
- R3: The last init write puts 0x00 into the receive-mode register at short address 0x00. Its bits 1:0 select the mode (0 normal, 1 promiscuous, 2 error), so this write selects normal mode.
- R4: A channel request with `chan_i` from 11 to 26 first writes long address 0x200 with the value ((chan_i − 11) << 4) | 0x03.
- R5: After the channel write, the sequencer writes short address 0x36 with 0x04 and then with 0x00, and issues no further writes.
- R6: After the last channel-sequence write is acknowledged, `busy_o` stays high with `cmd_valid_o` low for exactly CLK_HZ/1,000,000 × 192 cycles. `done_o` then pulses for one cycle as `busy_o` falls.
- R7: A channel request with `chan_i` outside 11 to 26 gives a one-cycle `err_o` pulse. No write is issued and `busy_o` stays low.
- R8: A command stays on the port, with `cmd_valid_o` high and long/address/data unchanged, until the cycle in which `cmd_ack_i` is high. Only one command is presented at a time.
- R9: `busy_o` is high from the cycle after an accepted request until completion. Start and channel requests that arrive while busy are ignored.
- R10: When `start_i` and `chan_req_i` arrive together while idle, the init sequence runs and the channel request is dropped.
- R11: After the last init write is acknowledged, `done_o` pulses for one cycle in the next cycle, with no settling wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to run the init sequence |
| chan_req_i | input | 1 | One-cycle request to change channel |
| chan_i | input | CHAN_W | Requested channel number, sampled with `chan_req_i` |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse when a sequence completes |
| err_o | output | 1 | One-cycle pulse when a channel request is rejected |
| cmd_valid_o | output | 1 | A write command is presented |
| cmd_long_o | output | 1 | 1 = long write (10-bit address), 0 = short write (address in bits 5:0) |
| cmd_addr_o | output | 10 | Register address |
| cmd_data_o | output | 8 | Data byte |
| cmd_ack_i | input | 1 | Serialiser accepts the presented command this cycle |

## Verification
A wrong step index or a lost transition shows up on the command port at the very next acknowledge. The log of accepted writes then differs from the expected list in order, address or data, or it gains or loses entries. A wrong settle-counter load or compare does not show on the command port. It shows only as a mismatch in the count of quiet busy cycles, which the bench checks against the cycle number it computes from the clock parameter. That count is complete when `done_o` arrives, about two thousand cycles after the last write in the bench configuration. A bad guard on busy or range shows within one cycle as a spurious write, a missing or extra `err_o` pulse, or a second `done_o`.

// File: rtl/rfseq_pkg.sv
package rfseq_pkg;

    localparam int IDX_W      = 5;
    localparam int INIT_STEPS = 16;

    localparam logic [9:0] A_RF_CTRL  = 10'h036;
    localparam logic [9:0] A_CHAN_REG = 10'h200;
    localparam logic [9:0] A_RX_MODE  = 10'h000;

    localparam logic [7:0] RF_RST_SET = 8'h04;
    localparam logic [7:0] RF_RST_CLR = 8'h00;

    typedef struct packed {
        logic       lng;
        logic [9:0] addr;
        logic [7:0] data;
    } wr_cmd_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_INIT,
        S_CHAN,
        S_SETTLE
    } seq_state_t;

    typedef struct packed {
        seq_state_t       st;
        logic [IDX_W-1:0] idx;
        wr_cmd_t          cmd;
        logic             vld;
        logic             done;
        logic             err;
    } ctl_t;

endpackage

// File: rtl/rfseq_init_rom.sv
module rfseq_init_rom
    import rfseq_pkg::*;
(
    input  logic [IDX_W-1:0] idx_i,
    output wr_cmd_t          cmd_o
);

    always_comb begin
        unique case (idx_i)
            5'd0:    cmd_o = '{lng: 1'b0, addr: 10'h02A, data: 8'h07};
            5'd1:    cmd_o = '{lng: 1'b0, addr: 10'h018, data: 8'h98};
            5'd2:    cmd_o = '{lng: 1'b0, addr: 10'h02E, data: 8'h95};
            5'd3:    cmd_o = '{lng: 1'b1, addr: 10'h200, data: 8'h03};
            5'd4:    cmd_o = '{lng: 1'b1, addr: 10'h201, data: 8'h01};
            5'd5:    cmd_o = '{lng: 1'b1, addr: 10'h202, data: 8'h80};
            5'd6:    cmd_o = '{lng: 1'b1, addr: 10'h206, data: 8'h90};
            5'd7:    cmd_o = '{lng: 1'b1, addr: 10'h207, data: 8'h80};
            5'd8:    cmd_o = '{lng: 1'b1, addr: 10'h208, data: 8'h10};
            5'd9:    cmd_o = '{lng: 1'b1, addr: 10'h220, data: 8'h21};
            5'd10:   cmd_o = '{lng: 1'b0, addr: 10'h03A, data: 8'h80};
            5'd11:   cmd_o = '{lng: 1'b0, addr: 10'h03F, data: 8'h60};
            5'd12:   cmd_o = '{lng: 1'b0, addr: 10'h03E, data: 8'h40};
            5'd13:   cmd_o = '{lng: 1'b0, addr: A_RF_CTRL, data: RF_RST_SET};
            5'd14:   cmd_o = '{lng: 1'b0, addr: A_RF_CTRL, data: RF_RST_CLR};
            5'd15:   cmd_o = '{lng: 1'b0, addr: A_RX_MODE, data: 8'h00};
            default: cmd_o = '{lng: 1'b0, addr: 10'h000, data: 8'h00};
        endcase
    end

endmodule

// File: rtl/rfseq_chan_enc.sv
module rfseq_chan_enc #(
    parameter int CHAN_W = 5,
    parameter int CH_MIN = 11,
    parameter int CH_MAX = 26
) (
    input  logic [CHAN_W-1:0] chan_i,
    output logic              ok_o,
    output logic [7:0]        val_o
);

    logic [3:0] off;

    always_comb begin
        ok_o  = (int'(chan_i) >= CH_MIN) && (int'(chan_i) <= CH_MAX);
        off   = 4'(chan_i - CHAN_W'(CH_MIN));
        val_o = {off, 4'h3};
    end

endmodule

// File: rtl/rfseq_settle.sv
module rfseq_settle #(
    parameter int CYCLES = 9600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic fire_o
);

    localparam int CYC = (CYCLES < 1) ? 1 : CYCLES;
    localparam int CW  = $clog2(CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          run;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d      = q;
        fire_o = q.run && (q.cnt == '0);
        if (load_i) begin
            d.cnt = CW'(CYC - 1);
            d.run = 1'b1;
        end else if (q.run) begin
            if (q.cnt == '0) begin
                d.run = 1'b0;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/rfseq_ctrl.sv
module rfseq_ctrl
    import rfseq_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int SETTLE_US = 192,
    parameter int CHAN_W    = 5,
    parameter int CH_MIN    = 11,
    parameter int CH_MAX    = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              chan_req_i,
    input  logic [CHAN_W-1:0] chan_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              cmd_valid_o,
    output logic              cmd_long_o,
    output logic [9:0]        cmd_addr_o,
    output logic [7:0]        cmd_data_o,
    input  logic              cmd_ack_i
);

    localparam int SETTLE_CYC = (CLK_HZ / 1_000_000) * SETTLE_US;
    localparam logic [IDX_W-1:0] LAST_INIT = IDX_W'(INIT_STEPS - 1);

    ctl_t q, d;

    logic [IDX_W-1:0] rom_idx;
    wr_cmd_t          rom_cmd;
    logic             ch_ok;
    logic [7:0]       ch_val;
    logic             settle_load;
    logic             settle_fire;

    rfseq_init_rom u_rom (
        .idx_i (rom_idx),
        .cmd_o (rom_cmd)
    );

    rfseq_chan_enc #(
        .CHAN_W (CHAN_W),
        .CH_MIN (CH_MIN),
        .CH_MAX (CH_MAX)
    ) u_enc (
        .chan_i (chan_i),
        .ok_o   (ch_ok),
        .val_o  (ch_val)
    );

    rfseq_settle #(
        .CYCLES (SETTLE_CYC)
    ) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (settle_load),
        .fire_o (settle_fire)
    );

    always_comb begin
        rom_idx = (q.st == S_INIT) ? q.idx + 1'b1 : '0;
    end

    always_comb begin
        d           = q;
        d.done      = 1'b0;
        d.err       = 1'b0;
        settle_load = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    d.st  = S_INIT;
                    d.idx = '0;
                    d.cmd = rom_cmd;
                    d.vld = 1'b1;
                end else if (chan_req_i) begin
                    if (ch_ok) begin
                        d.st  = S_CHAN;
                        d.idx = '0;
                        d.cmd = '{lng: 1'b1, addr: A_CHAN_REG, data: ch_val};
                        d.vld = 1'b1;
                    end else begin
                        d.err = 1'b1;
                    end
                end
            end
            S_INIT: begin
                if (cmd_ack_i) begin
                    if (q.idx == LAST_INIT) begin
                        d.st   = S_IDLE;
                        d.vld  = 1'b0;
                        d.done = 1'b1;
                    end else begin
                        d.idx = q.idx + 1'b1;
                        d.cmd = rom_cmd;
                    end
                end
            end
            S_CHAN: begin
                if (cmd_ack_i) begin
                    d.idx = q.idx + 1'b1;
                    if (q.idx == IDX_W'(0)) begin
                        d.cmd = '{lng: 1'b0, addr: A_RF_CTRL, data: RF_RST_SET};
                    end else if (q.idx == IDX_W'(1)) begin
                        d.cmd = '{lng: 1'b0, addr: A_RF_CTRL, data: RF_RST_CLR};
                    end else begin
                        d.st        = S_SETTLE;
                        d.vld       = 1'b0;
                        settle_load = 1'b1;
                    end
                end
            end
            S_SETTLE: begin
                if (settle_fire) begin
                    d.st   = S_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, idx: '0, cmd: '0, vld: 1'b0, done: 1'b0, err: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy_o      = (q.st != S_IDLE);
    assign done_o      = q.done;
    assign err_o       = q.err;
    assign cmd_valid_o = q.vld;
    assign cmd_long_o  = q.cmd.lng;
    assign cmd_addr_o  = q.cmd.addr;
    assign cmd_data_o  = q.cmd.data;

endmodule

// File: rtl/rfseq_ctrl_chk.sv
module rfseq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       chan_req_i,
    input logic       busy_o,
    input logic       done_o,
    input logic       err_o,
    input logic       cmd_valid_o,
    input logic       cmd_long_o,
    input logic [9:0] cmd_addr_o,
    input logic [7:0] cmd_data_o,
    input logic       cmd_ack_i
);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && !cmd_ack_i |=> cmd_valid_o && $stable(cmd_long_o)
            && $stable(cmd_addr_o) && $stable(cmd_data_o));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !cmd_valid_o);

    p_start_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o |=> busy_o && !err_o);

    p_req_answered_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chan_req_i && !start_i && !busy_o |=> busy_o != err_o);

    p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !busy_o && !cmd_valid_o && !done_o);

    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && !cmd_valid_o);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_short_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && !cmd_long_o |-> cmd_addr_o[9:6] == 4'h0);

    p_chan_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && cmd_long_o && cmd_addr_o == 10'h200 |-> cmd_data_o[3:0] == 4'h3);

endmodule

bind rfseq_ctrl rfseq_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .chan_req_i  (chan_req_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .cmd_valid_o (cmd_valid_o),
    .cmd_long_o  (cmd_long_o),
    .cmd_addr_o  (cmd_addr_o),
    .cmd_data_o  (cmd_data_o),
    .cmd_ack_i   (cmd_ack_i)
);

// File: tb/rfseq_ctrl_bench.sv
module rfseq_ctrl_bench;

    localparam int CLK_HZ = 10_000_000;
    localparam int SETTLE = (CLK_HZ / 1_000_000) * 192;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       chan_req = 1'b0;
    logic [4:0] chan = '0;
    logic       busy, done, err, cvld, clong, ack;
    logic [9:0] caddr;
    logic [7:0] cdata;

    int checks = 0;
    int fails = 0;
    int log_n = 0;
    int quiet = 0;
    int done_cnt = 0;
    int err_cnt = 0;
    int wcnt = 0;
    int seed = 7;
    logic [18:0] log_c [0:63];

    always #10 clk = ~clk;

    rfseq_ctrl #(.CLK_HZ(CLK_HZ)) u_rfseq_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .chan_req_i  (chan_req),
        .chan_i      (chan),
        .busy_o      (busy),
        .done_o      (done),
        .err_o       (err),
        .cmd_valid_o (cvld),
        .cmd_long_o  (clong),
        .cmd_addr_o  (caddr),
        .cmd_data_o  (cdata),
        .cmd_ack_i   (ack)
    );

    initial ack = 1'b0;

    // Serialiser model: accepts after a varying delay, logs what it accepts.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cvld && wcnt == 0) begin
                if (log_n < 64) log_c[log_n] = {clong, caddr, cdata};
                log_n = log_n + 1;
                ack = 1'b1;
                seed = (seed * 5 + 3) % 256;
                wcnt = seed % 3;
            end else begin
                ack = 1'b0;
                if (cvld && wcnt > 0) wcnt = wcnt - 1;
            end
            if (busy && !cvld) quiet = quiet + 1;
            if (done) done_cnt = done_cnt + 1;
            if (err) err_cnt = err_cnt + 1;
        end
    end

    function automatic logic [18:0] exp_init(input int i);
        case (i)
            0:  return {1'b0, 10'h02A, 8'h07};
            1:  return {1'b0, 10'h018, 8'h98};
            2:  return {1'b0, 10'h02E, 8'h95};
            3:  return {1'b1, 10'h200, 8'h03};
            4:  return {1'b1, 10'h201, 8'h01};
            5:  return {1'b1, 10'h202, 8'h80};
            6:  return {1'b1, 10'h206, 8'h90};
            7:  return {1'b1, 10'h207, 8'h80};
            8:  return {1'b1, 10'h208, 8'h10};
            9:  return {1'b1, 10'h220, 8'h21};
            10: return {1'b0, 10'h03A, 8'h80};
            11: return {1'b0, 10'h03F, 8'h60};
            12: return {1'b0, 10'h03E, 8'h40};
            13: return {1'b0, 10'h036, 8'h04};
            14: return {1'b0, 10'h036, 8'h00};
            default: return {1'b0, 10'h000, 8'h00};
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        log_n = 0; quiet = 0; done_cnt = 0; err_cnt = 0;
    endtask

    task automatic pulse(input logic s, input logic c, input logic [4:0] ch);
        @(negedge clk);
        start = s; chan_req = c; chan = ch;
        @(negedge clk);
        start = 1'b0; chan_req = 1'b0;
    endtask

    task automatic wait_end();
        while (done_cnt == 0 && err_cnt == 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_init(input string tag);
        chk({tag, " R2 init write count"}, log_n, 16);
        for (int i = 0; i < 15; i++)
            chk({tag, " R2 init write"}, int'(log_c[i]), int'(exp_init(i)));
        chk({tag, " R3 rx-mode normal write"}, int'(log_c[15]), int'({1'b0, 10'h000, 8'h00}));
        chk({tag, " R11 no settle wait after init"}, quiet, 0);
        chk({tag, " R11 single done pulse"}, done_cnt, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 valid after reset", int'(cvld), 0);
        chk("R1 done after reset", int'(done), 0);
        chk("R1 err after reset", int'(err), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Init with requests injected while busy (R9)
        clear_log();
        pulse(1'b1, 1'b0, 5'd0);
        repeat (4) @(negedge clk);
        chk("R9 busy during init", int'(busy), 1);
        pulse(1'b1, 1'b1, 5'd15);
        wait_end();
        check_init("first");
        chk("R9 no error from ignored request", err_cnt, 0);
        chk("R1 idle after init", int'(busy), 0);

        // Sweep of every channel code
        for (int ch = 0; ch < 32; ch++) begin
            clear_log();
            pulse(1'b0, 1'b1, 5'(ch));
            if (ch >= 11 && ch <= 26) begin
                repeat (2) @(negedge clk);
                pulse(1'b0, 1'b1, 5'(ch == 11 ? 12 : 11));
                wait_end();
                chk("R5 channel write count", log_n, 3);
                chk("R4 channel register write", int'(log_c[0]),
                    int'({1'b1, 10'h200, 4'(ch - 11), 4'h3}));
                chk("R5 rf reset set", int'(log_c[1]), int'({1'b0, 10'h036, 8'h04}));
                chk("R5 rf reset clear", int'(log_c[2]), int'({1'b0, 10'h036, 8'h00}));
                chk("R6 settle cycles", quiet, SETTLE);
                chk("R6 single done pulse", done_cnt, 1);
                chk("R9 ignored request no error", err_cnt, 0);
            end else begin
                wait_end();
                chk("R7 reject error pulse", err_cnt, 1);
                chk("R7 no writes on reject", log_n, 0);
                chk("R7 no done on reject", done_cnt, 0);
                chk("R7 not busy on reject", int'(busy), 0);
            end
        end

        // Simultaneous start and channel request (R10)
        clear_log();
        pulse(1'b1, 1'b1, 5'd20);
        wait_end();
        check_init("tie R10");
        chk("R10 no error on tie", err_cnt, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails = fails + 1;
        $display("FAIL watchdog R6 actual=hung expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule